// File: doc/BRIEF.md
# Audio serial data port

This block is the master end of a stereo audio serial link. From an oversampled system clock it makes a bit clock and a frame clock. Each frame it shifts a left and a right transmit sample out on a serial data line and collects a left and a right receive sample from a serial data input. A one-cycle strobe marks the frame boundary. At that strobe the next transmit pair is taken from the parallel inputs and the receive pair just completed is presented on the parallel outputs.

A small set of control inputs selects the framing:
- left-justified (the reset choice);
- I2S-style;
- a DSP short-frame mode, in which two extra bits pick the bit-clock edge sense and the frame-pulse phase.

A mute bit forces the serial output low. Control values are sampled only at the frame boundary, so a frame never mixes two formats. Each sample is SAMPLE_W bits (default 16), sent MSB first, left channel first, so a frame is 2*SAMPLE_W bit clocks long. One bit clock lasts 2*CLK_DIV system clocks.

Top module: `audio_sport`

## Requirements
- R1: While reset is held, and immediately after it, the active configuration is left-justified (format code 10) with edge-flip, early-pulse and mute all 0. The outputs are then sck_o=0, fs_o=1, sd_o=0, rx_left=0, rx_right=0 and frame_stb=0.
- R2: sck_o has a period of 2*CLK_DIV system clocks and is low for the first half of each bit slot. Outside DSP mode, and in DSP mode with edge-flip=1, sd_o changes only on a falling sck_o edge and sd_i is sampled at the rising sck_o edge in the middle of the slot.
- R3: In DSP mode (format code 00) with edge-flip=0, sck_o is inverted. sd_o then changes only on a rising sck_o edge and sd_i is sampled on the falling edge.
- R4: In left-justified mode (format codes 10 and 11), fs_o is high for the 16 left bit slots and low for the 16 right ones. The left MSB appears in the slot that begins at the rise of fs_o. Each sample is sent MSB first, left before right.
- R5: In I2S mode (format code 01), fs_o falls one bit slot before the left MSB and is low for 16 slots. It then rises one bit slot before the right MSB.
- R6: In DSP mode, fs_o is a pulse one bit slot wide in each frame. With early-pulse=0 it rises half a slot before the left MSB slot. With early-pulse=1 it rises one full slot before it.
- R7: While the active mute bit is 1, sd_o is 0 for the whole frame.
- R8: sd_i is captured once per bit slot, MSB first, left sample then right sample. The completed pair appears on rx_left/rx_right in the strobe cycle and is held until the next strobe.
- R9: frame_stb is high for exactly one system clock every 4*SAMPLE_W*CLK_DIV clocks; the first pulse comes that many clocks after reset is released. The transmit pair present at the strobe edge is sent in the following frame. The first frame after reset sends zeros.
- R10: A change on the control inputs in mid-frame has no effect until the next frame boundary. The current frame keeps its format, edge sense, pulse phase and mute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Frame format: 00 DSP, 01 I2S, 10/11 left-justified |
| dsp_edge_flip | input | 1 | DSP mode bit-clock edge sense |
| dsp_early_fs | input | 1 | DSP mode frame pulse one full bit early |
| sdo_mute | input | 1 | Hold serial output low |
| tx_left | input | SAMPLE_W | Left transmit sample |
| tx_right | input | SAMPLE_W | Right transmit sample |
| sd_i | input | 1 | Serial data input |
| sck_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame clock |
| sd_o | output | 1 | Serial data output |
| rx_left | output | SAMPLE_W | Last received left sample |
| rx_right | output | SAMPLE_W | Last received right sample |
| frame_stb | output | 1 | One-cycle frame boundary strobe |

## Verification
The hardest cases to reach are control changes that land in the middle of a frame, and the DSP frame pulse, which begins in the last slot of one frame under the old settings and ends in the first slot of the next frame under the new ones. The stimulus changes the control inputs at an offset well inside a frame and holds them across at least two boundaries. For every cycle in which the pending and active settings differ, the per-cycle comparison against the behavioural model is tagged to the deferred-update rule. The bench also drives a known, frame-indexed pattern on sd_i so that every received pair can be predicted. The transmit samples change at times unrelated to the frame, so only the value present at the strobe edge counts.

// File: rtl/sport_pkg.sv
package sport_pkg;

    typedef enum logic [1:0] {
        FMT_DSP = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_LJ2 = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic edge_flip;
        logic early_fs;
        logic mute;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{fmt: FMT_LJ, edge_flip: 1'b0, early_fs: 1'b0, mute: 1'b0};

endpackage

// File: rtl/sport_timebase.sv
module sport_timebase #(
    parameter int CLK_DIV = 2,
    parameter int PHASES  = 64,
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
    localparam int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic            half_end,
    output logic            frame_end
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph;
    } tb_state_t;

    tb_state_t state_d, state_q;

    always_comb begin
        state_d   = state_q;
        half_end  = (state_q.div == DIV_W'(CLK_DIV - 1));
        frame_end = half_end && (state_q.ph == PH_W'(PHASES - 1));
        if (half_end) begin
            state_d.div = '0;
            state_d.ph  = (state_q.ph == PH_W'(PHASES - 1)) ? '0 : state_q.ph + 1'b1;
        end else begin
            state_d.div = state_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ph = state_q.ph;

endmodule

// File: rtl/sport_pins.sv
module sport_pins
    import sport_pkg::*;
#(
    parameter int PHASES = 64,
    localparam int PH_W  = $clog2(PHASES),
    localparam int LAST  = PHASES - 1,
    localparam int HALFP = PHASES / 2
) (
    input  logic [PH_W-1:0] ph,
    input  cfg_t            cfg,
    output logic            sck,
    output logic            fs
);

    logic bit_hi;

    always_comb begin
        bit_hi = ph[0];
        // DSP with clear edge-flip: the pin clock is inverted so launch lands on a rising edge
        sck = ((cfg.fmt == FMT_DSP) && !cfg.edge_flip) ? ~bit_hi : bit_hi;
        case (cfg.fmt)
            FMT_I2S: fs = (ph >= PH_W'(HALFP - 2)) && (ph <= PH_W'(LAST - 2));
            FMT_DSP: fs = (ph == PH_W'(LAST)) ||
                          (cfg.early_fs ? (ph == PH_W'(LAST - 1)) : (ph == '0));
            default: fs = (ph < PH_W'(HALFP));
        endcase
    end

endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_end,
    input  logic              bit_hi,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] tx_load,
    input  logic              sd_i,
    output logic              tx_msb,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (frame_end) begin
            sh_d.tx = tx_load;
        end else if (half_end && bit_hi) begin
            sh_d.tx = {sh_q.tx[WORD_W-2:0], 1'b0};
        end
        // capture at the middle of each bit slot
        if (half_end && !bit_hi) begin
            sh_d.rx = {sh_q.rx[WORD_W-2:0], sd_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tx_msb  = sh_q.tx[WORD_W-1];
    assign rx_word = sh_q.rx;

endmodule

// File: rtl/audio_sport.sv
module audio_sport
    import sport_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CLK_DIV  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic                dsp_edge_flip,
    input  logic                dsp_early_fs,
    input  logic                sdo_mute,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                sd_i,
    output logic                sck_o,
    output logic                fs_o,
    output logic                sd_o,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                frame_stb
);

    localparam int WORD_W    = 2 * SAMPLE_W;
    localparam int PHASES    = 2 * WORD_W;
    localparam int PH_W      = $clog2(PHASES);
    localparam int FRAME_CYC = PHASES * CLK_DIV;

    typedef struct packed {
        cfg_t                cfg;
        logic                stb;
        logic [SAMPLE_W-1:0] rxl;
        logic [SAMPLE_W-1:0] rxr;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [PH_W-1:0]   ph;
    logic              half_end;
    logic              frame_end;
    logic              tx_msb;
    logic [WORD_W-1:0] rx_word;
    cfg_t              act_cfg;

    sport_timebase #(.CLK_DIV(CLK_DIV), .PHASES(PHASES)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .half_end  (half_end),
        .frame_end (frame_end)
    );

    sport_pins #(.PHASES(PHASES)) u_pins (
        .ph  (ph),
        .cfg (top_q.cfg),
        .sck (sck_o),
        .fs  (fs_o)
    );

    sport_shifter #(.WORD_W(WORD_W)) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_end  (half_end),
        .bit_hi    (ph[0]),
        .frame_end (frame_end),
        .tx_load   ({tx_left, tx_right}),
        .sd_i      (sd_i),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    always_comb begin
        top_d     = top_q;
        top_d.stb = 1'b0;
        if (frame_end) begin
            top_d.cfg.fmt       = fmt_e'(fmt_sel);
            top_d.cfg.edge_flip = dsp_edge_flip;
            top_d.cfg.early_fs  = dsp_early_fs;
            top_d.cfg.mute      = sdo_mute;
            top_d.stb           = 1'b1;
            top_d.rxl           = rx_word[WORD_W-1:SAMPLE_W];
            top_d.rxr           = rx_word[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q     <= '0;
            top_q.cfg <= CFG_RESET;
        end else begin
            top_q <= top_d;
        end
    end

    assign act_cfg   = top_q.cfg;
    assign sd_o      = top_q.cfg.mute ? 1'b0 : tx_msb;
    assign rx_left   = top_q.rxl;
    assign rx_right  = top_q.rxr;
    assign frame_stb = top_q.stb;

endmodule

// File: rtl/sport_chk.sv
module sport_chk
    import sport_pkg::*;
#(
    parameter int FRAME_CYC = 128,
    localparam int CW       = $clog2(FRAME_CYC) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic sck_o,
    input logic sd_o,
    input logic frame_stb,
    input cfg_t act_cfg
);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         since_q <= '0;
        else if (frame_stb) since_q <= CW'(1);
        else                since_q <= since_q + 1'b1;
    end

    // R3
    dsp_launch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sd_o) && !frame_stb && act_cfg.fmt == FMT_DSP && !act_cfg.edge_flip) |-> $rose(sck_o));

    // R2
    std_launch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sd_o) && !frame_stb && !(act_cfg.fmt == FMT_DSP && !act_cfg.edge_flip)) |-> $fell(sck_o));

    // R7
    mute_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.mute |-> !sd_o);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R9
    stb_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (since_q == CW'(FRAME_CYC)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> $stable(act_cfg));

endmodule

bind audio_sport sport_chk #(.FRAME_CYC(FRAME_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_o     (sck_o),
    .sd_o      (sd_o),
    .frame_stb (frame_stb),
    .act_cfg   (act_cfg)
);

// File: tb/sim_audio_sport.sv
`timescale 1ns/1ps
module sim_audio_sport;

    localparam int SW     = 16;
    localparam int DIV    = 2;
    localparam int WW     = 2 * SW;
    localparam int PHASES = 2 * WW;
    localparam int FC     = PHASES * DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fmt_sel = 2'b10;
    logic          dsp_edge_flip = 1'b0;
    logic          dsp_early_fs = 1'b0;
    logic          sdo_mute = 1'b0;
    logic [SW-1:0] tx_left = 16'hA55A;
    logic [SW-1:0] tx_right = 16'h1234;
    logic          sd_i = 1'b0;
    logic          sck_o, fs_o, sd_o, frame_stb;
    logic [SW-1:0] rx_left, rx_right;

    int total = 0;
    int bad = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_sport #(.SAMPLE_W(SW), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .dsp_edge_flip(dsp_edge_flip),
        .dsp_early_fs(dsp_early_fs), .sdo_mute(sdo_mute), .tx_left(tx_left),
        .tx_right(tx_right), .sd_i(sd_i), .sck_o(sck_o), .fs_o(fs_o), .sd_o(sd_o),
        .rx_left(rx_left), .rx_right(rx_right), .frame_stb(frame_stb)
    );

    function automatic logic [WW-1:0] rx_pat(input int f);
        logic [31:0] v;
        v = 32'(f);
        return (v * 32'h9E3779B1) ^ {v[15:0], 16'hC3A5};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // reference model state (value after each clock edge)
    int            mn;
    logic [1:0]    mfmt;
    logic          mflip, mearly, mmute, mstb;
    logic [WW-1:0] mtx;
    logic [SW-1:0] mrxl, mrxr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mn = 0; mfmt = 2'b10; mflip = 0; mearly = 0; mmute = 0;
            mstb = 0; mtx = '0; mrxl = '0; mrxr = '0;
        end else begin
            mn = mn + 1;
            mstb = 0;
            if (mn % FC == 0) begin
                mfmt = fmt_sel; mflip = dsp_edge_flip; mearly = dsp_early_fs; mmute = sdo_mute;
                mtx = {tx_left, tx_right};
                {mrxl, mrxr} = rx_pat(mn / FC - 1);
                mstb = 1;
            end
        end
    end

    always @(negedge clk) begin
        int  mph;
        bit  esck, efs, esd, pend;
        string t_sck, t_fs, t_sd;
        if (run && rst_n) begin
            mph  = (mn / DIV) % PHASES;
            pend = {fmt_sel, dsp_edge_flip, dsp_early_fs, sdo_mute} != {mfmt, mflip, mearly, mmute};
            esck = (mfmt == 2'b00 && !mflip) ? ~mph[0] : mph[0];
            case (mfmt)
                2'b01:   efs = (mph >= PHASES/2 - 2) && (mph <= PHASES - 3);
                2'b00:   efs = (mph == PHASES - 1) || (mearly ? (mph == PHASES - 2) : (mph == 0));
                default: efs = (mph < PHASES/2);
            endcase
            esd = mmute ? 1'b0 : mtx[WW - 1 - mph/2];
            t_sck = pend ? "R10 sck" : ((mfmt == 2'b00) ? "R3 sck" : "R2 sck");
            t_fs  = pend ? "R10 fs" : ((mfmt == 2'b00) ? "R6 fs" : ((mfmt == 2'b01) ? "R5 fs" : "R4 fs"));
            t_sd  = pend ? "R10 sd" : (mmute ? "R7 sd" : "R4 sd");
            check(t_sck, 32'(sck_o), 32'(esck));
            check(t_fs, 32'(fs_o), 32'(efs));
            check(t_sd, 32'(sd_o), 32'(esd));
            check("R9 strobe", 32'(frame_stb), 32'(mstb));
            check("R8 rx_left", 32'(rx_left), 32'(mrxl));
            check("R8 rx_right", 32'(rx_right), 32'(mrxr));
            // next serial input bit for the slot now in progress
            sd_i = rx_pat(mn / FC)[WW - 1 - mph/2];
            if (mn % 53 == 7)  tx_left  = {tx_left[14:0], tx_left[15] ^ tx_left[13] ^ tx_left[12] ^ tx_left[10]};
            if (mn % 71 == 19) tx_right = tx_right * 16'd5 + 16'd7;
        end
    end

    task automatic set_cfg(input logic [1:0] f, input logic fl, input logic er, input logic mu);
        fmt_sel = f; dsp_edge_flip = fl; dsp_early_fs = er; sdo_mute = mu;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 sck", 32'(sck_o), 32'd0);
        check("R1 fs", 32'(fs_o), 32'd1);
        check("R1 sd", 32'(sd_o), 32'd0);
        check("R1 rx_left", 32'(rx_left), 32'd0);
        check("R1 rx_right", 32'(rx_right), 32'd0);
        check("R1 strobe", 32'(frame_stb), 32'd0);
        rst_n = 1'b1;
        run = 1'b1;
        repeat (2 * FC + 40) @(negedge clk);
        set_cfg(2'b01, 0, 0, 0);  // I2S, applied mid-frame
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b00, 0, 0, 0);  // DSP, normal edge, half-bit pulse
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b00, 1, 0, 0);
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b00, 1, 1, 0);
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b00, 0, 1, 0);
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b10, 0, 0, 1);  // muted left-justified
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b11, 0, 0, 0);
        repeat (2 * FC) @(negedge clk);
        set_cfg(2'b01, 0, 0, 1);
        repeat (2 * FC) @(negedge clk);
        run = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule